// File: doc/BRIEF.md
# Bidirectional FIFO Port Controller with Mailbox

This block is the control logic for one side of a pair of FIFOs that carry data in opposite directions. Each port clock cycle it decodes four control pins: chip select (active low), a write/read select, an enable and a mailbox select. From them it issues a push strobe to the outbound FIFO or a pop strobe to the inbound FIFO. When mailbox select is high it instead writes a single-word outbound mail register or reads a single-word inbound mail register. The FIFO storage sits outside the block. The block only needs the FIFO's ready flags, its strobes and its data buses.

The port's data pins are driven only during a read selection, and an output-enable flag reports this. A multiplexer then chooses what the pins show. With mailbox select low they show the register that holds the last word popped from the inbound FIFO. With mailbox select high they show the inbound mail register.

Each mail register has an empty flag. A high flag means no unread mail. Writing a mail register drops its flag, and a read by the receiving side raises it again. The far port writes the inbound mail register and reads the outbound one through a small strobe interface.

Top module: `port_ctrl`

## Requirements
- R1: `dout_oe` is 1 exactly when `cs_n` is 0 and `wr_sel` is 0. It does not depend on `en`, `mbx_sel` or the clock.
- R2: With `cs_n`=0, `wr_sel`=1, `en`=1 and `mbx_sel`=0, `fifo_push` is 1 in the same cycle if `fifo_wr_ready` is 1, and is 0 if it is 0. `fifo_push_data` always equals `din`.
- R3: With `cs_n`=0, `wr_sel`=0, `en`=1, `mbx_sel`=0 and `fifo_rd_ready`=1, `fifo_pop` is 1 in that cycle. The rising edge loads `fifo_pop_data` into the FIFO output register.
- R4: When `fifo_rd_ready` is 0, a FIFO read selection gives no `fifo_pop`, and the FIFO output register keeps its value.
- R5: With `cs_n`=0, `wr_sel`=1, `en`=1 and `mbx_sel`=1, the rising edge loads `din` into `mail_out_data` and drives `mail_out_empty` to 0. No push occurs.
- R6: A `far_mail_rd` pulse sets `mail_out_empty` to 1 at the next edge. If a local mail write happens at the same edge, the write wins and the flag goes to 0.
- R7: With `cs_n`=0, `wr_sel`=0, `en`=1 and `mbx_sel`=1, the rising edge sets `mail_in_empty` to 1. If a `far_mail_wr` happens at the same edge, the far write wins: the flag goes to 0 and the new word is stored.
- R8: A `far_mail_wr` pulse loads `far_mail_data` into the inbound mail register and drives `mail_in_empty` to 0.
- R9: While `dout_oe` is 1, `dout` shows the inbound mail register when `mbx_sel` is 1 and the FIFO output register when `mbx_sel` is 0. This holds whatever the value of `en`.
- R10: With `en`=0 there is no push, no pop and no change to either mail flag or to the outbound mail register, whatever `cs_n`, `wr_sel` and `mbx_sel` are.
- R11: While `rst` is 1, `fifo_push` and `fifo_pop` are 0. After reset both mail flags are 1, and both the FIFO output register and the inbound mail register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_sel | input | 1 | 1 selects a write cycle, 0 a read cycle |
| en | input | 1 | Enables the operation at the clock edge |
| mbx_sel | input | 1 | 1 selects the mail registers in place of the FIFO path |
| din | input | W | Data entering from the port pins |
| dout | output | W | Data presented to the port pins |
| dout_oe | output | 1 | Output enable for the port pins |
| fifo_wr_ready | input | 1 | Outbound FIFO can accept a word |
| fifo_push | output | 1 | Push strobe to the outbound FIFO |
| fifo_push_data | output | W | Word pushed into the outbound FIFO |
| fifo_rd_ready | input | 1 | Inbound FIFO holds a word |
| fifo_pop | output | 1 | Pop strobe to the inbound FIFO |
| fifo_pop_data | input | W | Head word of the inbound FIFO |
| mail_out_data | output | W | Outbound mail register contents |
| mail_out_empty | output | 1 | 1 when the outbound mail has been read |
| far_mail_rd | input | 1 | Far port reads the outbound mail |
| far_mail_wr | input | 1 | Far port writes the inbound mail |
| far_mail_data | input | W | Word written by the far port |
| mail_in_empty | output | 1 | 1 when the inbound mail has been read |

## Verification
The bench sweeps all sixteen combinations of chip select, write/read select, enable and mailbox select against all four combinations of the two FIFO ready flags. For each case it predicts the strobes, the output enable, the pin data and the flags after the edge. The sweep separates FIFO and mail paths, separates reads from writes, tells gating by the ready flags apart from gating by enable, and confirms that cases with enable low change nothing. Separate directed cycles collide a local mail access with the far port's access to the same register, to pin down which one wins. A reset held with a push-shaped control pattern checks that no strobe leaks out.

// File: rtl/port_ctrl_pkg.sv
package port_ctrl_pkg;

    localparam int DATA_W = 36;

    typedef struct packed {
        logic cs_n;
        logic wr_sel;
        logic en;
        logic mbx_sel;
    } port_ctl_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_MAIL_WR = 3'd3,
        OP_MAIL_RD = 3'd4
    } port_op_e;

    // Cycle type requested by the control pins, before any ready gating.
    function automatic port_op_e decode_op(port_ctl_t c);
        port_op_e op;
        op = OP_NONE;
        if (!c.cs_n && c.en) begin
            case ({c.wr_sel, c.mbx_sel})
                2'b10:   op = OP_PUSH;
                2'b11:   op = OP_MAIL_WR;
                2'b00:   op = OP_POP;
                default: op = OP_MAIL_RD;
            endcase
        end
        return op;
    endfunction

    function automatic logic drives_pins(port_ctl_t c);
        return !c.cs_n && !c.wr_sel;
    endfunction

endpackage

// File: rtl/port_decode.sv
module port_decode
    import port_ctrl_pkg::*;
(
    input  logic      rst,
    input  port_ctl_t ctl,
    input  logic      wr_ready,
    input  logic      rd_ready,
    output logic      push,
    output logic      pop,
    output logic      mail_wr,
    output logic      mail_rd,
    output logic      oe
);
    port_op_e op;

    always_comb begin
        op      = decode_op(ctl);
        push    = !rst && (op == OP_PUSH) && wr_ready;
        pop     = !rst && (op == OP_POP) && rd_ready;
        mail_wr = !rst && (op == OP_MAIL_WR);
        mail_rd = !rst && (op == OP_MAIL_RD);
        oe      = drives_pins(ctl);
    end
endmodule

// File: rtl/mail_slot.sv
module mail_slot #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            data  <= wr_data;
            empty <= 1'b0;
        end else if (rd) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pop,
    input  logic [W-1:0] pop_data,
    input  logic [W-1:0] mail_data,
    input  logic         mbx_sel,
    output logic [W-1:0] dout
);
    logic [W-1:0] fifo_q;

    always_ff @(posedge clk) begin
        if (rst)      fifo_q <= '0;
        else if (pop) fifo_q <= pop_data;
    end

    always_comb dout = mbx_sel ? mail_data : fifo_q;
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import port_ctrl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         wr_sel,
    input  logic         en,
    input  logic         mbx_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    input  logic         fifo_wr_ready,
    output logic         fifo_push,
    output logic [W-1:0] fifo_push_data,
    input  logic         fifo_rd_ready,
    output logic         fifo_pop,
    input  logic [W-1:0] fifo_pop_data,
    output logic [W-1:0] mail_out_data,
    output logic         mail_out_empty,
    input  logic         far_mail_rd,
    input  logic         far_mail_wr,
    input  logic [W-1:0] far_mail_data,
    output logic         mail_in_empty
);
    port_ctl_t    ctl;
    logic         mail_wr;
    logic         mail_rd;
    logic [W-1:0] mail_in_data;

    always_comb begin
        ctl.cs_n    = cs_n;
        ctl.wr_sel  = wr_sel;
        ctl.en      = en;
        ctl.mbx_sel = mbx_sel;
    end

    assign fifo_push_data = din;

    port_decode u_decode (
        .rst      (rst),
        .ctl      (ctl),
        .wr_ready (fifo_wr_ready),
        .rd_ready (fifo_rd_ready),
        .push     (fifo_push),
        .pop      (fifo_pop),
        .mail_wr  (mail_wr),
        .mail_rd  (mail_rd),
        .oe       (dout_oe)
    );

    // Written here, read by the far port.
    mail_slot #(.W(W)) u_mail_out (
        .clk     (clk),
        .rst     (rst),
        .wr      (mail_wr),
        .wr_data (din),
        .rd      (far_mail_rd),
        .data    (mail_out_data),
        .empty   (mail_out_empty)
    );

    // Written by the far port, read here.
    mail_slot #(.W(W)) u_mail_in (
        .clk     (clk),
        .rst     (rst),
        .wr      (far_mail_wr),
        .wr_data (far_mail_data),
        .rd      (mail_rd),
        .data    (mail_in_data),
        .empty   (mail_in_empty)
    );

    out_stage #(.W(W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pop       (fifo_pop),
        .pop_data  (fifo_pop_data),
        .mail_data (mail_in_data),
        .mbx_sel   (mbx_sel),
        .dout      (dout)
    );
endmodule

// File: rtl/port_ctrl_chk.sv
module port_ctrl_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         wr_sel,
    input logic         en,
    input logic         mbx_sel,
    input logic [W-1:0] din,
    input logic         dout_oe,
    input logic         fifo_wr_ready,
    input logic         fifo_push,
    input logic         fifo_rd_ready,
    input logic         fifo_pop,
    input logic [W-1:0] mail_out_data,
    input logic         mail_out_empty,
    input logic         far_mail_rd,
    input logic         far_mail_wr,
    input logic         mail_in_empty
);
    logic lcl_mail_wr;
    logic lcl_mail_rd;
    assign lcl_mail_wr = !cs_n && wr_sel && en && mbx_sel;
    assign lcl_mail_rd = !cs_n && !wr_sel && en && mbx_sel;

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) dout_oe |-> (!cs_n && !wr_sel)); // R1
    AST_PUSH_GATED: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> (fifo_wr_ready && !cs_n && wr_sel && en && !mbx_sel)); // R2
    AST_POP_GATED: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_rd_ready && !cs_n && !wr_sel && en && !mbx_sel)); // R4
    AST_MAIL_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
        lcl_mail_wr |=> (!mail_out_empty && mail_out_data == $past(din))); // R5
    AST_FAR_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (far_mail_rd && !lcl_mail_wr) |=> mail_out_empty); // R6
    AST_MAIL_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (lcl_mail_rd && !far_mail_wr) |=> mail_in_empty); // R7
    AST_FAR_WR_FILLS: assert property (@(posedge clk) disable iff (rst)
        far_mail_wr |=> !mail_in_empty); // R8
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!fifo_push && !fifo_pop)); // R10
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !far_mail_wr && !far_mail_rd) |=> ($stable(mail_out_empty) && $stable(mail_in_empty))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (!fifo_push && !fifo_pop)); // R11
    AST_RESET_FLAGS: assert property (@(posedge clk) rst |=> (mail_out_empty && mail_in_empty)); // R11
endmodule

bind port_ctrl port_ctrl_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cs_n           (cs_n),
    .wr_sel         (wr_sel),
    .en             (en),
    .mbx_sel        (mbx_sel),
    .din            (din),
    .dout_oe        (dout_oe),
    .fifo_wr_ready  (fifo_wr_ready),
    .fifo_push      (fifo_push),
    .fifo_rd_ready  (fifo_rd_ready),
    .fifo_pop       (fifo_pop),
    .mail_out_data  (mail_out_data),
    .mail_out_empty (mail_out_empty),
    .far_mail_rd    (far_mail_rd),
    .far_mail_wr    (far_mail_wr),
    .mail_in_empty  (mail_in_empty)
);

// File: tb/test_port_ctrl.sv
module test_port_ctrl;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs_n, wr_sel, en, mbx_sel;
    logic [W-1:0] din, dout, fifo_push_data, fifo_pop_data, mail_out_data, far_mail_data;
    logic         dout_oe, fifo_wr_ready, fifo_push, fifo_rd_ready, fifo_pop;
    logic         mail_out_empty, far_mail_rd, far_mail_wr, mail_in_empty;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    port_ctrl #(.W(W)) i_port_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_sel(wr_sel), .en(en), .mbx_sel(mbx_sel),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .fifo_wr_ready(fifo_wr_ready), .fifo_push(fifo_push), .fifo_push_data(fifo_push_data),
        .fifo_rd_ready(fifo_rd_ready), .fifo_pop(fifo_pop), .fifo_pop_data(fifo_pop_data),
        .mail_out_data(mail_out_data), .mail_out_empty(mail_out_empty),
        .far_mail_rd(far_mail_rd), .far_mail_wr(far_mail_wr), .far_mail_data(far_mail_data),
        .mail_in_empty(mail_in_empty)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_ctl();
        cs_n = 1'b1; wr_sel = 1'b0; en = 1'b0; mbx_sel = 1'b0;
        far_mail_rd = 1'b0; far_mail_wr = 1'b0;
    endtask

    // Apply at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read a register through the pins with no operation (en low).
    task automatic peek(input logic sel, output logic [W-1:0] val);
        cs_n = 1'b0; wr_sel = 1'b0; en = 1'b0; mbx_sel = sel;
        #1 val = dout;
    endtask

    logic [W-1:0] exp_fifo_q, exp_mail_out, rd_val;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_ctl();
        din = '0; fifo_pop_data = '0; far_mail_data = '0;
        fifo_wr_ready = 1'b1; fifo_rd_ready = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        // R11: held reset with push-shaped and then pop-shaped controls
        cs_n = 1'b0; wr_sel = 1'b1; en = 1'b1; mbx_sel = 1'b0;
        #1 chk("R11 push during reset", W'(fifo_push), W'(0));
        wr_sel = 1'b0;
        #1 chk("R11 pop during reset", W'(fifo_pop), W'(0));
        step();
        idle_ctl();
        rst = 1'b0;
        #1;
        chk("R11 out flag after reset", W'(mail_out_empty), W'(1));
        chk("R11 in flag after reset", W'(mail_in_empty), W'(1));
        peek(1'b0, rd_val); chk("R11 fifo reg after reset", rd_val, '0);
        peek(1'b1, rd_val); chk("R11 in mail after reset", rd_val, '0);
        exp_fifo_q = '0;
        exp_mail_out = '0;

        // Sweep: 4 control bits x 2 ready flags
        for (int c = 0; c < 64; c++) begin
            logic t_cs_n, t_wr, t_en, t_mbx, t_wrdy, t_rrdy;
            logic [W-1:0] a_k, d_k, p_k;
            logic e_push, e_pop, e_mwr, e_mrd, e_oe;
            t_cs_n = c[0]; t_wr = c[1]; t_en = c[2]; t_mbx = c[3]; t_wrdy = c[4]; t_rrdy = c[5];
            a_k = {4'hA, 32'(c * 32'h01030507)};
            d_k = {4'h5, 32'(c * 32'h00110013 + 7)};
            p_k = {4'hC, 32'(c * 32'h10204081 + 3)};

            // Preset: inbound mail full with a_k, outbound mail read by far port
            idle_ctl();
            far_mail_wr = 1'b1; far_mail_data = a_k; far_mail_rd = 1'b1;
            step();
            idle_ctl();

            e_push = !t_cs_n && t_en && t_wr && !t_mbx && t_wrdy;
            e_pop  = !t_cs_n && t_en && !t_wr && !t_mbx && t_rrdy;
            e_mwr  = !t_cs_n && t_en && t_wr && t_mbx;
            e_mrd  = !t_cs_n && t_en && !t_wr && t_mbx;
            e_oe   = !t_cs_n && !t_wr;

            cs_n = t_cs_n; wr_sel = t_wr; en = t_en; mbx_sel = t_mbx;
            fifo_wr_ready = t_wrdy; fifo_rd_ready = t_rrdy;
            din = d_k; fifo_pop_data = p_k;
            #1;
            chk("R1 oe", W'(dout_oe), W'(e_oe));
            chk(t_en ? "R2 push" : "R10 push", W'(fifo_push), W'(e_push));
            chk("R2 push data", fifo_push_data, d_k);
            chk(t_en ? (t_rrdy ? "R3 pop" : "R4 pop") : "R10 pop", W'(fifo_pop), W'(e_pop));
            if (e_oe) chk("R9 mux", dout, t_mbx ? a_k : exp_fifo_q);
            step();
            idle_ctl();
            fifo_wr_ready = 1'b1; fifo_rd_ready = 1'b1;
            #1;
            if (e_pop) exp_fifo_q = p_k;
            if (e_mwr) exp_mail_out = d_k;
            chk(t_en ? "R5 out flag" : "R10 out flag", W'(mail_out_empty), W'(!e_mwr));
            chk(t_en ? "R5 out data" : "R10 out data", mail_out_data, exp_mail_out);
            chk(t_en ? "R7 in flag" : "R10 in flag", W'(mail_in_empty), W'(e_mrd));
            peek(1'b0, rd_val); chk(e_pop ? "R3 fifo reg" : "R4 fifo reg", rd_val, exp_fifo_q);
            peek(1'b1, rd_val); chk("R8 in mail", rd_val, a_k);
            idle_ctl();
        end

        // R6: far read alone, then a far read colliding with a local write
        idle_ctl();
        cs_n = 1'b0; wr_sel = 1'b1; en = 1'b1; mbx_sel = 1'b1; din = 36'h123456789;
        step();
        idle_ctl();
        #1 chk("R5 write flag", W'(mail_out_empty), W'(0));
        far_mail_rd = 1'b1;
        step();
        idle_ctl();
        #1 chk("R6 far read", W'(mail_out_empty), W'(1));
        cs_n = 1'b0; wr_sel = 1'b1; en = 1'b1; mbx_sel = 1'b1; din = 36'hFEDCBA987;
        far_mail_rd = 1'b1;
        step();
        idle_ctl();
        #1;
        chk("R6 collision flag", W'(mail_out_empty), W'(0));
        chk("R6 collision data", mail_out_data, 36'hFEDCBA987);

        // R7: local mail read colliding with a far write
        far_mail_wr = 1'b1; far_mail_data = 36'h0AAAA5555;
        step();
        idle_ctl();
        cs_n = 1'b0; wr_sel = 1'b0; en = 1'b1; mbx_sel = 1'b1;
        far_mail_wr = 1'b1; far_mail_data = 36'h955556666;
        step();
        idle_ctl();
        #1 chk("R7 collision flag", W'(mail_in_empty), W'(0));
        peek(1'b1, rd_val); chk("R7 collision data", rd_val, 36'h955556666);
        idle_ctl();
        cs_n = 1'b0; wr_sel = 1'b0; en = 1'b1; mbx_sel = 1'b1;
        step();
        idle_ctl();
        #1 chk("R7 read clears", W'(mail_in_empty), W'(1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule